// File: doc/BRIEF.md
# Queued Serial Transmitter with Selectable Framing

This block is the transmit half of an asynchronous serial port. Software writes characters of up to nine bits into a small queue. A frame engine takes them from the queue one at a time and sends each one on a single output line. A frame is a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Every bit lasts sixteen periods of a one-cycle baud tick that comes from an external divider.

Two enables control the block. The port enable switches the whole transmitter on or off. Turning it off aborts the frame in flight, empties the queue and resets the status flags, but leaves the framing configuration alone. The send enable decides whether queued characters may start. A character queued while sending is off starts at once when sending is switched on, with no wait for a baud tick. A character written while sending is already on and the line is idle waits for the next tick. An interrupt pulse reports one of two events, chosen by configuration: a queue entry being freed, or all traffic having drained.

Top module: `uart_txq`

## Requirements
- R1: The serial line `tx_o` is 1 whenever no frame is being sent.
- R2: An `en_wr` strobe with `en_mod`=0 aborts the frame in progress and empties the queue. From the next cycle, `tx_o`=1, `buf_full_o`=0, `xmit_en_o`=0 and `all_sent_o`=1.
- R3: After reset, the port enable and send enable are both 0 and the format is 8 data bits, no parity, one stop bit. A `data_wr` strobe while the port enable is 0 is ignored and the character is never sent.
- R4: `fmt_sel` selects the framing: 0 = 8 bits with no parity, 1 = 8 bits with even parity, 2 = 8 bits with odd parity, 3 = 9 bits with no parity. The parity bit follows the last data bit. With even parity the data bits plus the parity bit contain an even number of ones. With odd parity they contain an odd number.
- R5: The queue holds 4 characters, and the frame engine holds one more. `buf_full_o` is 1 exactly when the queue holds 4.
- R6: A `data_wr` while `buf_full_o`=1 is dropped. The queued characters keep their contents and their order.
- R7: When sending is enabled and the engine is idle, a written character is taken from the queue in the next cycle. Its start bit begins on the first baud tick after that, and `tx_o` stays 1 until then.
- R8: When a character was queued while sending was off, an `en_wr` that turns sending on drives `tx_o` low two clock cycles after the strobe cycle, with no baud tick needed.
- R9: `fmt_irq_sel`=0 gives one `irq_o` pulse of one cycle each time a character leaves the queue for the engine. `fmt_irq_sel`=1 gives one pulse each time the queue and engine become empty together.
- R10: Every start, data, parity and stop bit lasts 16 baud ticks. `fmt_two_stop`=1 sends two stop bits and `fmt_two_stop`=0 sends one.
- R11: `all_sent_o` is 1 exactly when no frame is in progress and the queue is empty.
- R12: The `fmt_wr` settings (format, stop count, interrupt source) keep their values across a port disable and re-enable.
- R13: In the 8-bit formats, bit 8 of `data_in` is ignored. In the 9-bit format, bit 8 is sent as the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Strobe that loads the two enable bits |
| en_mod | input | 1 | Port enable value written by `en_wr` |
| en_xmit | input | 1 | Send enable value written by `en_wr` (forced to 0 when `en_mod`=0) |
| fmt_wr | input | 1 | Strobe that loads the framing configuration |
| fmt_sel | input | 2 | Data and parity format code |
| fmt_two_stop | input | 1 | 1 = two stop bits |
| fmt_irq_sel | input | 1 | Interrupt source select |
| data_wr | input | 1 | Character write strobe |
| data_in | input | 9 | Character to queue |
| baud_tick | input | 1 | One-cycle tick, sixteen per bit |
| tx_o | output | 1 | Serial line |
| buf_full_o | output | 1 | Queue full |
| all_sent_o | output | 1 | Queue and engine both empty |
| xmit_en_o | output | 1 | Current send enable |
| irq_o | output | 1 | Transmit interrupt pulse |

## Verification
The bench fills the queue behind a frame that is waiting for a tick, then writes once more. A design that accepted or shifted on that write would send a sixth character or a reordered stream. It queues a character with sending off and then turns sending on with the tick generator stopped. A design that waited for a baud edge would keep the line high there. It disables the port in the middle of a frame with a full queue. A design that failed to abort or flush would leave the line low, or send stale characters once the port is enabled again. It also checks that odd parity with two stop bits is still in force after that re-enable, and that the ninth bit appears only in the 9-bit format.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    typedef enum logic [1:0] {
        FMT_8N = 2'b00,
        FMT_8E = 2'b01,
        FMT_8O = 2'b10,
        FMT_9N = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARMED,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

endpackage

// File: rtl/uart_txq_fifo.sv
module uart_txq_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               rd;
        logic [PW-1:0]               wr;
        logic [CW-1:0]               cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CNT_MAX);
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wr] = push_data;
            d.wr        = (q.wr == PTR_MAX) ? '0 : q.wr + 1'b1;
        end
        if (do_pop) begin
            d.rd = (q.rd == PTR_MAX) ? '0 : q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
        if (flush) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head  = q.mem[q.rd];
    assign full  = (q.cnt == CNT_MAX);
    assign empty = (q.cnt == '0);

endmodule

// File: rtl/uart_txq_shift.sv
module uart_txq_shift
    import uart_txq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            load,
    input  logic            load_now,
    input  logic [DATA_W:0] load_data,
    input  logic [1:0]      fmt,
    input  logic            two_stop,
    input  logic            baud_tick,
    output logic            tx,
    output logic            busy
);
    localparam int WORD_W = DATA_W + 1;
    localparam int SW     = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IW     = $clog2(WORD_W);
    localparam logic [SW-1:0] SUB_LAST  = SW'(OVS - 1);
    localparam logic [IW-1:0] LAST_WIDE = IW'(DATA_W);
    localparam logic [IW-1:0] LAST_NARR = IW'(DATA_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [SW-1:0]     sub;
        logic [IW-1:0]     idx;
        logic [IW-1:0]     last;
        logic [WORD_W-1:0] sreg;
        logic              par_en;
        logic              par_val;
        logic              stop_more;
    } shift_t;

    shift_t q, d;
    fmt_e   f;
    logic   bit_end;
    logic   in_bit;

    always_comb begin
        d       = q;
        f       = fmt_e'(fmt);
        in_bit  = (q.phase == PH_START) || (q.phase == PH_DATA) ||
                  (q.phase == PH_PAR)   || (q.phase == PH_STOP);
        bit_end = in_bit && baud_tick && (q.sub == SUB_LAST);

        if (in_bit && baud_tick) begin
            d.sub = bit_end ? '0 : q.sub + 1'b1;
        end

        case (q.phase)
            PH_IDLE: begin
                if (load) begin
                    d.sreg      = (f == FMT_9N) ? load_data
                                                : {1'b0, load_data[DATA_W-1:0]};
                    d.last      = (f == FMT_9N) ? LAST_WIDE : LAST_NARR;
                    d.par_en    = (f == FMT_8E) || (f == FMT_8O);
                    d.par_val   = (^load_data[DATA_W-1:0]) ^ (f == FMT_8O);
                    d.stop_more = two_stop;
                    d.idx       = '0;
                    d.sub       = '0;
                    d.phase     = load_now ? PH_START : PH_ARMED;
                end
            end
            PH_ARMED: begin
                if (baud_tick) begin
                    d.phase = PH_START;
                    d.sub   = '0;
                end
            end
            PH_START: begin
                if (bit_end) begin
                    d.phase = PH_DATA;
                    d.idx   = '0;
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    d.sreg = q.sreg >> 1;
                    if (q.idx == q.last) begin
                        d.phase = q.par_en ? PH_PAR : PH_STOP;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            PH_PAR: begin
                if (bit_end) begin
                    d.phase = PH_STOP;
                end
            end
            PH_STOP: begin
                if (bit_end) begin
                    if (q.stop_more) begin
                        d.stop_more = 1'b0;
                    end else begin
                        d.phase = PH_IDLE;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase

        if (abort) begin
            d.phase = PH_IDLE;
            d.sub   = '0;
            d.idx   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.phase)
            PH_START: tx = 1'b0;
            PH_DATA:  tx = q.sreg[0];
            PH_PAR:   tx = q.par_val;
            default:  tx = 1'b1;
        endcase
    end

    assign busy = (q.phase != PH_IDLE);

endmodule

// File: rtl/uart_txq.sv
module uart_txq
    import uart_txq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int OVS        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic            en_mod,
    input  logic            en_xmit,
    input  logic            fmt_wr,
    input  logic [1:0]      fmt_sel,
    input  logic            fmt_two_stop,
    input  logic            fmt_irq_sel,
    input  logic            data_wr,
    input  logic [DATA_W:0] data_in,
    input  logic            baud_tick,
    output logic            tx_o,
    output logic            buf_full_o,
    output logic            all_sent_o,
    output logic            xmit_en_o,
    output logic            irq_o
);
    localparam int WORD_W = DATA_W + 1;

    typedef struct packed {
        logic       mod_en;
        logic       xmit_en;
        logic [1:0] fmt;
        logic       two_stop;
        logic       irq_sel;
        logic       fresh;
        logic       empty_prev;
        logic       irq;
    } ctl_t;

    ctl_t              q, d;
    logic              disable_req;
    logic              load;
    logic              push;
    logic              all_sent;
    logic              sh_busy;
    logic              sh_tx;
    logic              fifo_full;
    logic              fifo_empty;
    logic [WORD_W-1:0] fifo_head;

    always_comb begin
        d           = q;
        disable_req = en_wr && !en_mod;
        push        = data_wr && q.mod_en;
        load        = q.mod_en && q.xmit_en && !sh_busy && !fifo_empty;
        all_sent    = !sh_busy && fifo_empty;

        if (en_wr) begin
            d.mod_en  = en_mod;
            d.xmit_en = en_mod && en_xmit;
        end
        if (fmt_wr) begin
            d.fmt      = fmt_sel;
            d.two_stop = fmt_two_stop;
            d.irq_sel  = fmt_irq_sel;
        end

        d.fresh      = !q.xmit_en;
        d.empty_prev = all_sent;
        d.irq        = q.mod_en && !disable_req &&
                       (q.irq_sel ? (all_sent && !q.empty_prev) : load);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.fmt        <= FMT_8N;
            q.fresh      <= 1'b1;
            q.empty_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    uart_txq_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (WORD_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (disable_req),
        .push      (push),
        .push_data (data_in),
        .pop       (load),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    uart_txq_shift #(
        .DATA_W (DATA_W),
        .OVS    (OVS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (disable_req),
        .load      (load),
        .load_now  (q.fresh),
        .load_data (fifo_head),
        .fmt       (q.fmt),
        .two_stop  (q.two_stop),
        .baud_tick (baud_tick),
        .tx        (sh_tx),
        .busy      (sh_busy)
    );

    assign tx_o       = sh_tx;
    assign buf_full_o = fifo_full;
    assign all_sent_o = all_sent;
    assign xmit_en_o  = q.xmit_en;
    assign irq_o      = q.irq;

endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk (
    input logic clk,
    input logic rst_n,
    input logic en_wr,
    input logic en_mod,
    input logic tx_o,
    input logic buf_full_o,
    input logic all_sent_o,
    input logic xmit_en_o,
    input logic irq_o,
    input logic load
);
    // R1: an empty transmitter keeps the line high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        all_sent_o |-> tx_o);

    // R2: a port disable leaves every flag in its cleared state
    p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_mod) |=> (!buf_full_o && all_sent_o && !xmit_en_o && tx_o));

    // R6: a full queue stays full until an entry leaves or the port is disabled
    p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full_o && !load && !(en_wr && !en_mod)) |=> buf_full_o);

    // R7: a character taken by the engine means traffic is pending
    p_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !(en_wr && !en_mod)) |=> !all_sent_o);

    // R9: the interrupt is a single-cycle pulse
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
endmodule

bind uart_txq uart_txq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (en_wr),
    .en_mod     (en_mod),
    .tx_o       (tx_o),
    .buf_full_o (buf_full_o),
    .all_sent_o (all_sent_o),
    .xmit_en_o  (xmit_en_o),
    .irq_o      (irq_o),
    .load       (load)
);

// File: tb/uart_txq_tb.sv
module uart_txq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr = 1'b0, en_mod = 1'b0, en_xmit = 1'b0;
    logic       fmt_wr = 1'b0, fmt_two_stop = 1'b0, fmt_irq_sel = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic       data_wr = 1'b0;
    logic [8:0] data_in = '0;
    logic       baud_tick = 1'b0;
    logic       tx_o, buf_full_o, all_sent_o, xmit_en_o, irq_o;

    always #4 clk = ~clk;

    uart_txq u_dut (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_mod(en_mod), .en_xmit(en_xmit),
        .fmt_wr(fmt_wr), .fmt_sel(fmt_sel), .fmt_two_stop(fmt_two_stop),
        .fmt_irq_sel(fmt_irq_sel), .data_wr(data_wr), .data_in(data_in),
        .baud_tick(baud_tick), .tx_o(tx_o), .buf_full_o(buf_full_o),
        .all_sent_o(all_sent_o), .xmit_en_o(xmit_en_o), .irq_o(irq_o)
    );

    typedef struct {
        logic [8:0] data;
        logic [1:0] fmt;
        logic       two;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errs = 0;
    int         frames = 0;
    int         irq_cnt = 0;
    logic       tick_on = 1'b0;
    logic       mon_on = 1'b1;
    logic [1:0] cur_fmt = 2'b00;
    logic       cur_two = 1'b0;

    always @(negedge clk) begin
        if (!tick_on) baud_tick <= 1'b0;
        else          baud_tick <= !baud_tick;
    end

    always @(negedge clk) begin
        if (rst_n && irq_o === 1'b1) irq_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (baud_tick) k++;
        end
        #1;
    endtask

    // scoreboard monitor: decodes each frame at mid-bit and compares with the queue
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && mon_on && tx_o === 1'b0) begin
                exp_t       e;
                logic [8:0] got;
                logic [8:0] want;
                int         nb;
                logic       exp_par;
                wait_ticks(8);
                chk(tx_o == 1'b0, "R10", "start bit level", tx_o, 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R6", "frame with no queued character", 1, 0);
                    e = '{9'h0, 2'b00, 1'b0};
                end else begin
                    e = sb.pop_front();
                end
                nb  = (e.fmt == 2'b11) ? 9 : 8;
                got = '0;
                for (int i = 0; i < nb; i++) begin
                    wait_ticks(16);
                    got[i] = tx_o;
                end
                want = (nb == 9) ? e.data : {1'b0, e.data[7:0]};
                chk(got == want, "R13", "received data", got, want);
                if (e.fmt == 2'b01 || e.fmt == 2'b10) begin
                    wait_ticks(16);
                    exp_par = (e.fmt == 2'b01) ? ^e.data[7:0] : ~^e.data[7:0];
                    chk(tx_o == exp_par, "R4", "parity bit", tx_o, exp_par);
                end
                wait_ticks(16);
                chk(tx_o == 1'b1, "R10", "first stop bit", tx_o, 1);
                if (e.two) begin
                    wait_ticks(16);
                    chk(tx_o == 1'b1, "R10", "second stop bit", tx_o, 1);
                end
                frames++;
            end
        end
    end

    task automatic set_en(input logic m, input logic x);
        @(negedge clk);
        en_wr = 1'b1; en_mod = m; en_xmit = x;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic set_fmt(input logic [1:0] f, input logic two, input logic sel);
        @(negedge clk);
        fmt_wr = 1'b1; fmt_sel = f; fmt_two_stop = two; fmt_irq_sel = sel;
        @(negedge clk);
        fmt_wr = 1'b0;
        cur_fmt = f;
        cur_two = two;
    endtask

    task automatic put(input logic [8:0] v, input bit expect_sent);
        @(negedge clk);
        data_wr = 1'b1; data_in = v;
        if (expect_sent) sb.push_back('{v, cur_fmt, cur_two});
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic drain(input string req);
        int guard = 0;
        tick_on = 1'b1;
        while ((sb.size() != 0 || all_sent_o !== 1'b1) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (40) @(negedge clk);
        chk(sb.size() == 0, req, "scoreboard drained", sb.size(), 0);
        chk(all_sent_o == 1'b1, "R11", "empty after drain", all_sent_o, 1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int irq0;
        int f0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state, R1 idle line, R11 empty flag
        chk(tx_o == 1'b1, "R1", "idle line after reset", tx_o, 1);
        chk(buf_full_o == 1'b0, "R3", "full flag after reset", buf_full_o, 0);
        chk(all_sent_o == 1'b1, "R11", "empty flag after reset", all_sent_o, 1);
        chk(xmit_en_o == 1'b0, "R3", "send enable after reset", xmit_en_o, 0);
        chk(irq_o == 1'b0, "R3", "irq after reset", irq_o, 0);

        // R3: write while the port is disabled is ignored
        put(9'h055, 1'b0);
        repeat (5) @(negedge clk);
        chk(all_sent_o == 1'b1, "R3", "write ignored while disabled", all_sent_o, 1);
        set_en(1'b1, 1'b1);
        tick_on = 1'b1;
        repeat (100) @(negedge clk);
        chk(frames == 0, "R3", "ignored write never sent", frames, 0);
        chk(xmit_en_o == 1'b1, "R3", "send enable set", xmit_en_o, 1);

        // R3 default format 8N1, R13 bit 8 ignored in 8-bit mode
        put(9'h1A5, 1'b1);
        drain("R3");

        // R7: enabled and idle, frame waits for a tick
        tick_on = 1'b0;
        repeat (3) @(negedge clk);
        put(9'h03C, 1'b1);
        repeat (20) @(negedge clk);
        chk(tx_o == 1'b1, "R7", "line held until baud tick", tx_o, 1);
        chk(all_sent_o == 1'b0, "R11", "pending frame clears empty", all_sent_o, 0);
        drain("R7");

        // R4 formats, R10 two stop bits, R13 nine-bit data
        set_fmt(2'b01, 1'b0, 1'b0);
        put(9'h037, 1'b1); put(9'h036, 1'b1);
        drain("R4");
        set_fmt(2'b10, 1'b0, 1'b0);
        put(9'h037, 1'b1); put(9'h001, 1'b1);
        drain("R4");
        set_fmt(2'b11, 1'b0, 1'b0);
        put(9'h155, 1'b1); put(9'h0AA, 1'b1);
        drain("R13");
        set_fmt(2'b00, 1'b1, 1'b0);
        put(9'h081, 1'b1); put(9'h07E, 1'b1);
        drain("R10");

        // R5 full flag, R6 dropped write, R9 per-entry interrupt
        set_fmt(2'b00, 1'b0, 1'b0);
        tick_on = 1'b0;
        repeat (3) @(negedge clk);
        irq0 = irq_cnt;
        put(9'h011, 1'b1);
        put(9'h012, 1'b1);
        put(9'h013, 1'b1);
        put(9'h014, 1'b1);
        chk(buf_full_o == 1'b0, "R5", "not full with three queued", buf_full_o, 0);
        put(9'h015, 1'b1);
        chk(buf_full_o == 1'b1, "R5", "full with four queued", buf_full_o, 1);
        put(9'h099, 1'b0);
        chk(buf_full_o == 1'b1, "R6", "still full after dropped write", buf_full_o, 1);
        f0 = frames;
        drain("R6");
        chk(frames - f0 == 5, "R5", "five characters sent", frames - f0, 5);
        chk(irq_cnt - irq0 == 5, "R9", "entry-freed pulses", irq_cnt - irq0, 5);
        chk(buf_full_o == 1'b0, "R5", "not full after drain", buf_full_o, 0);

        // R9: drained-interrupt source
        set_fmt(2'b00, 1'b0, 1'b1);
        tick_on = 1'b0;
        repeat (3) @(negedge clk);
        irq0 = irq_cnt;
        put(9'h021, 1'b1);
        put(9'h022, 1'b1);
        drain("R9");
        chk(irq_cnt - irq0 == 1, "R9", "all-empty pulses", irq_cnt - irq0, 1);

        // R8: queued while sending is off, start without a tick
        set_fmt(2'b00, 1'b0, 1'b0);
        set_en(1'b1, 1'b0);
        tick_on = 1'b0;
        repeat (3) @(negedge clk);
        put(9'h05A, 1'b1);
        repeat (10) @(negedge clk);
        chk(tx_o == 1'b1, "R8", "held while sending off", tx_o, 1);
        chk(all_sent_o == 1'b0, "R11", "queued char clears empty", all_sent_o, 0);
        @(negedge clk);
        en_wr = 1'b1; en_mod = 1'b1; en_xmit = 1'b1;
        @(negedge clk);
        en_wr = 1'b0;
        @(negedge clk);
        chk(tx_o == 1'b0, "R8", "immediate start bit", tx_o, 0);
        drain("R8");

        // R2 disable mid-frame with full queue, R12 config retained
        set_fmt(2'b10, 1'b1, 1'b0);
        mon_on = 1'b0;
        tick_on = 1'b1;
        put(9'h040, 1'b0);
        repeat (60) @(negedge clk);
        tick_on = 1'b0;
        put(9'h041, 1'b0); put(9'h042, 1'b0); put(9'h043, 1'b0); put(9'h044, 1'b0);
        chk(buf_full_o == 1'b1, "R2", "full before disable", buf_full_o, 1);
        chk(all_sent_o == 1'b0, "R11", "busy before disable", all_sent_o, 0);
        set_en(1'b0, 1'b1);
        chk(tx_o == 1'b1, "R2", "line high after abort", tx_o, 1);
        chk(buf_full_o == 1'b0, "R2", "full cleared", buf_full_o, 0);
        chk(all_sent_o == 1'b1, "R2", "empty set", all_sent_o, 1);
        chk(xmit_en_o == 1'b0, "R2", "send enable cleared", xmit_en_o, 0);
        put(9'h077, 1'b0);
        tick_on = 1'b1;
        repeat (50) @(negedge clk);
        chk(all_sent_o == 1'b1, "R3", "write ignored after disable", all_sent_o, 1);
        chk(tx_o == 1'b1, "R1", "line idle while disabled", tx_o, 1);
        set_en(1'b1, 1'b1);
        mon_on = 1'b1;
        f0 = frames;
        put(9'h03C, 1'b1);
        put(9'h0C3, 1'b1);
        drain("R12");
        chk(frames - f0 == 2, "R12", "frames after re-enable", frames - f0, 2);

        finish_run();
    end
endmodule